// File: doc/BRIEF.md
# Serial Controller Register Front End

This block is the register side of a serial controller that sits on a simple 32-bit memory-mapped bus. Software reaches seven word registers through a word-addressed request port: a status word, a character data word, a baud divisor, three control words and a guard/prescaler word. Reads and writes of the status and data words have side effects on the status flags. Outgoing characters leave one byte at a time on a transmit stream. Incoming characters arrive one byte at a time on a receive stream.

The receive stream uses a valid/ready handshake. A byte is taken in any cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is a level that depends only on two control bits, and a byte offered while it is low stays with the sender. The transmit stream has no back-pressure. `tx_valid` is a one-cycle strobe and the consumer must take `tx_data` in that cycle.

A bus request is one cycle with `bus_valid` high. A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. Any side effect of an access takes effect on the same clock edge. The one interrupt line is a level.

Top module: `usart_regs`

## Requirements
- R1: After reset, the status word (word 0) reads 0x00C00000, every other register reads 0, `irq` is low and `rx_ready` is low.
- R2: A read request returns data one cycle later with `bus_rvalid` high. Any word index above 6 reads as 0, and a write to such an index changes no register.
- R3: A status read returns the status value as it was before the access, and afterwards clears transmit-complete (status bit 6).
- R4: A read of the data word (word 1) returns the last received byte, masked to the low 10 bits, and afterwards sets transmit-empty (status bit 7).
- R5: A data-word write with a value below 0xF000 does two things in the next cycle. It drives `tx_valid` high for one cycle with `tx_data` equal to the low byte, and it sets status bit 6. A data-word write of 0xF000 or above changes nothing and sends nothing.
- R6: A status write with a value of 0x3FF or less loads the value into the status word. A larger value is ANDed into the current status word.
- R7: `rx_ready` is high exactly when control-1 (word 3) has bit 13 (unit enable) and bit 3 (transmitter enable) both set. A byte offered while `rx_ready` is low is not taken.
- R8: A byte that is taken replaces the data word contents and sets receive-not-empty (status bit 5). This happens even when a status write in the same cycle clears that bit.
- R9: `irq` is high exactly when status bit 5 and control-1 bit 5 (receive interrupt enable) are both set. Clearing either one drops it.
- R10: The baud (word 2), control-1, control-2, control-3 (words 3 to 5) and guard (word 6) words read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Word index within the 0x2000-byte region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after the request |
| tx_data | output | 8 | Outgoing character |
| tx_valid | output | 1 | Outgoing character strobe (no back-pressure) |
| rx_data | input | 8 | Incoming character |
| rx_valid | input | 1 | Incoming character offered |
| rx_ready | output | 1 | Block can take an incoming character |
| irq | output | 1 | Receive interrupt level |

## Verification
The bench drives the value thresholds on both sides of their limits:
- Data writes of 0xEFFF and 0xF000. A design with an off-by-one comparison would either send the character at 0xF000 or stay silent at 0xEFFF.
- Status writes of 0x3FF and 0x400. Getting this wrong turns a load into an AND-clear or the reverse.

It also offers receive bytes with only one of the two enable bits set. A design that checks a single bit would take those bytes and overwrite the data word.

Other cases target the ordering of effects:
- A status read followed by a second status read must show transmit-complete set and then clear.
- A receive in the same cycle as a status write that clears receive-not-empty must leave the flag set.
- An interrupt must fall when either its flag or its enable is removed.

// File: rtl/usart_regs_pkg.sv
package usart_regs_pkg;
  localparam int NREG = 7;
  localparam int NCFG = 5;
  localparam int CFG_BASE = 2;
  localparam int IDX_STAT = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_CTL1 = 3;
  localparam int CFG_CTL1 = IDX_CTL1 - CFG_BASE;

  localparam int ST_TXE  = 7;
  localparam int ST_TC   = 6;
  localparam int ST_RXNE = 5;
  localparam int C1_UEN  = 13;
  localparam int C1_RXIE = 5;
  localparam int C1_TEN  = 3;

  localparam logic [31:0] STAT_RST   = 32'h00C0_0000;
  localparam logic [31:0] TX_LIMIT   = 32'h0000_F000;
  localparam logic [31:0] LOAD_LIMIT = 32'h0000_03FF;
  localparam logic [31:0] DATA_MASK  = 32'h0000_03FF;
endpackage

// File: rtl/usart_addr_dec.sv
module usart_addr_dec #(
  parameter int ADDR_W = 11,
  parameter int NSEL   = 7
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEL-1:0]   sel
);
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel[g] = req && (addr == ADDR_W'(g));
  end
endmodule

// File: rtl/usart_cfg_bank.sv
module usart_cfg_bank #(
  parameter int N = 5,
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [N-1:0]      sel,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q[g] <= '0;
      else if (wr && sel[g]) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/usart_status_reg.sv
module usart_status_reg
  import usart_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat,
  input  logic        rd_stat,
  input  logic        rd_data,
  input  logic        tx_send,
  input  logic        rx_take,
  input  logic [31:0] wdata,
  output logic [31:0] stat_q
);
  logic [31:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (wr_stat) nxt = (wdata <= LOAD_LIMIT) ? wdata : (stat_q & wdata);
    if (rd_stat) nxt[ST_TC]  = 1'b0;
    if (rd_data) nxt[ST_TXE] = 1'b1;
    if (tx_send) nxt[ST_TC]  = 1'b1;
    if (rx_take) nxt[ST_RXNE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= nxt;
  end
endmodule

// File: rtl/usart_regs.sv
module usart_regs
  import usart_regs_pkg::*;
#(
  parameter int REGION_BYTES = 8192,
  localparam int ADDR_W = $clog2(REGION_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq
);
  logic [NREG-1:0]        sel;
  logic [NCFG-1:0][31:0]  cfg_q;
  logic [31:0]            stat_q;
  logic [7:0]             data_q;
  logic [31:0]            rd_mux;
  logic rd_req, wr_req, tx_send, rx_take;

  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid && bus_write;

  usart_addr_dec #(.ADDR_W(ADDR_W), .NSEL(NREG)) u_dec (
    .req(bus_valid), .addr(bus_addr), .sel(sel)
  );

  usart_cfg_bank #(.N(NCFG), .W(32)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(wr_req),
    .sel(sel[NREG-1:CFG_BASE]), .wdata(bus_wdata), .q(cfg_q)
  );

  assign rx_ready = cfg_q[CFG_CTL1][C1_UEN] && cfg_q[CFG_CTL1][C1_TEN];
  assign rx_take  = rx_valid && rx_ready;
  assign tx_send  = wr_req && sel[IDX_DATA] && (bus_wdata < TX_LIMIT);

  usart_status_reg u_stat (
    .clk(clk), .rst_n(rst_n),
    .wr_stat(wr_req && sel[IDX_STAT]),
    .rd_stat(rd_req && sel[IDX_STAT]),
    .rd_data(rd_req && sel[IDX_DATA]),
    .tx_send(tx_send), .rx_take(rx_take),
    .wdata(bus_wdata), .stat_q(stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (rx_take) data_q <= rx_data;
  end

  always_comb begin
    rd_mux = '0;
    if (sel[IDX_STAT]) rd_mux = stat_q;
    if (sel[IDX_DATA]) rd_mux = 32'(data_q) & DATA_MASK;
    for (int i = 0; i < NCFG; i++)
      if (sel[CFG_BASE + i]) rd_mux = cfg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req)  bus_rdata <= rd_mux;
      tx_valid <= tx_send;
      if (tx_send) tx_data <= bus_wdata[7:0];
    end
  end

  assign irq = stat_q[ST_RXNE] && cfg_q[CFG_CTL1][C1_RXIE];
endmodule

// File: rtl/usart_regs_chk.sv
module usart_regs_chk
  import usart_regs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic              tx_valid,
  input logic [7:0]        rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [31:0]       stat,
  input logic [31:0]       ctl1,
  input logic [7:0]        dreg
);
  // R2
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));

  // R3
  stat_read_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(IDX_STAT)) |=> !stat[ST_TC]);

  // R4
  data_read_sets_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(IDX_DATA)) |=> stat[ST_TXE]);

  // R5
  high_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(IDX_DATA) && bus_wdata >= TX_LIMIT)
      |=> !tx_valid);

  // R5
  tx_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_valid && bus_write && bus_addr == ADDR_W'(IDX_DATA)));

  // R8
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (stat[ST_RXNE] && dreg == $past(rx_data)));

  // R7
  rx_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(dreg));

  // R9
  irq_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && ctl1[C1_RXIE] &&
     !(bus_valid && bus_write && bus_addr == ADDR_W'(IDX_CTL1))) |=> irq);
endmodule

bind usart_regs usart_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .tx_valid(tx_valid), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .irq(irq), .stat(stat_q),
  .ctl1(cfg_q[usart_regs_pkg::CFG_CTL1]), .dreg(data_q)
);

// File: tb/tb_usart_regs.sv
module tb_usart_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 0;
  logic        rx_ready;
  logic        irq;

  always #2 clk = ~clk;

  usart_regs dut (.*);

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  // reference model state
  logic [31:0] m_stat, m_cfg [0:4];
  logic [7:0]  m_data, e_txd;
  logic [31:0] e_rd;
  logic        e_rv, e_tv;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model();
    bit rdy;
    if (!rst_n) begin
      m_stat = 32'h00C0_0000; m_data = 0; e_rv = 0; e_tv = 0; e_rd = 0; e_txd = 0;
      for (int i = 0; i < 5; i++) m_cfg[i] = 0;
      return;
    end
    rdy = m_cfg[1][13] & m_cfg[1][3];
    e_rv = 0; e_tv = 0;
    if (bus_valid && !bus_write) begin
      e_rv = 1;
      if (bus_addr == 0) e_rd = m_stat;
      else if (bus_addr == 1) e_rd = {24'd0, m_data};
      else if (bus_addr < 7) e_rd = m_cfg[bus_addr - 2];
      else e_rd = 0;
      if (bus_addr == 0) m_stat[6] = 0;
      if (bus_addr == 1) m_stat[7] = 1;
    end
    if (bus_valid && bus_write) begin
      if (bus_addr == 0) m_stat = (bus_wdata <= 32'h3FF) ? bus_wdata : (m_stat & bus_wdata);
      else if (bus_addr == 1) begin
        if (bus_wdata < 32'hF000) begin e_tv = 1; e_txd = bus_wdata[7:0]; m_stat[6] = 1; end
      end else if (bus_addr < 7) m_cfg[bus_addr - 2] = bus_wdata;
    end
    if (rx_valid && rdy) begin m_data = rx_data; m_stat[5] = 1; end
  endtask

  task automatic compare();
    chk(bus_rvalid == e_rv, "R2 rvalid", 32'(bus_rvalid), 32'(e_rv));
    if (e_rv) chk(bus_rdata == e_rd, cur_tag, bus_rdata, e_rd);
    chk(tx_valid == e_tv, "R5 tx_valid", 32'(tx_valid), 32'(e_tv));
    if (e_tv) chk(tx_data == e_txd, "R5 tx_data", 32'(tx_data), 32'(e_txd));
    chk(rx_ready == (m_cfg[1][13] & m_cfg[1][3]), "R7 rx_ready", 32'(rx_ready),
        32'(m_cfg[1][13] & m_cfg[1][3]));
    chk(irq == (m_stat[5] & m_cfg[1][5]), "R9 irq", 32'(irq), 32'(m_stat[5] & m_cfg[1][5]));
  endtask

  task automatic step();
    @(posedge clk); model();
    @(negedge clk); compare();
    bus_valid = 0; bus_write = 0; rx_valid = 0;
  endtask

  task automatic rd(input int a, input string tag);
    cur_tag = tag; bus_valid = 1; bus_write = 0; bus_addr = 11'(a); step();
  endtask
  task automatic wr(input int a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = 11'(a); bus_wdata = d; step();
  endtask
  task automatic rx(input logic [7:0] b);
    rx_valid = 1; rx_data = b; step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset values
    for (int a = 0; a < 7; a++) rd(a, "R1 reset");
    // R2 undecoded reads and writes
    rd(7, "R2 undecoded"); rd(2047, "R2 undecoded");
    wr(9, 32'hFFFF_FFFF); wr(2047, 32'h1234_5678);
    for (int a = 0; a < 9; a++) rd(a, "R2 after stray write");
    // R10 config readback
    wr(2, 32'h0000_0683); wr(4, 32'hA5A5_5A5A); wr(5, 32'h0000_0FFF); wr(6, 32'h1234_ABCD);
    wr(3, 32'h0000_2000);
    for (int a = 2; a < 7; a++) rd(a, "R10 readback");
    // R6 status load/AND thresholds
    wr(0, 32'h3FF); rd(0, "R6 load 3FF");
    wr(0, 32'h0000_0400); rd(0, "R6 and 400");
    wr(0, 32'h0000_00E0); wr(0, 32'hFFFF_FF7F); rd(0, "R6 and mask");
    // R5 transmit thresholds, R3 TC clear
    wr(1, 32'h0000_0041); rd(0, "R3 TC set"); rd(0, "R3 TC cleared");
    wr(1, 32'h0000_EFFF); wr(1, 32'h0000_F000); wr(1, 32'hFFFF_FFFF);
    rd(0, "R5 status after tx"); rd(0, "R3 TC cleared again");
    // R7 partial enables block rx
    rx(8'h11); rd(1, "R7 blocked both off");
    wr(3, 32'h0000_0008); rx(8'h22); rd(1, "R7 blocked TE only");
    wr(3, 32'h0000_2000); rx(8'h33); rd(1, "R7 blocked UE only");
    // R8 accepted, replacing; R4 data read sets TXE
    wr(0, 32'h0); wr(3, 32'h0000_2008);
    rx(8'hA5); rd(1, "R4 data read"); rd(0, "R4 TXE set");
    rx(8'h3C); rx(8'hC3); rd(1, "R8 replaced");
    // R9 irq on/off via flag and via enable
    wr(0, 32'h0); wr(3, 32'h0000_2028); rx(8'h7E); step();
    wr(0, 32'h0); step();
    rx(8'h01); wr(3, 32'h0000_2008); step();
    wr(3, 32'h0000_2028); step();
    // R8 rx same cycle as status write clearing RXNE
    rx_valid = 1; rx_data = 8'h99; wr(0, 32'h0); rd(0, "R8 rx beats clear"); rd(1, "R8 data");
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule